// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

This block holds a small set of list entries that present virtual interrupts to a guest CPU interface. Each entry carries a virtual interrupt number, a physical interrupt number, a hardware-link flag and a two-bit state. The hypervisor loads entries through a write port and inspects them through a read port. The guest side has two operations. An acknowledge returns the highest-priority pending entry, where the lowest index wins. A deactivate names a virtual interrupt that the guest has finished handling.

For an entry without the link flag, deactivation takes it out of the active state. For a linked entry, deactivation leaves the entry's state alone. The block instead sends a one-cycle request that carries the physical number toward the physical distributor, and it marks the entry as forwarded. Only a later software write clears the entry. The link flag also restricts the states software may load: a linked entry may be pending or active, but never both at once.

Top module: `lrb_bank`

## Requirements
- R1: A software write with `sw_wr_en` high loads the addressed entry's virtual ID, physical ID, link flag and state, and clears its forwarded flag. The read port shows these values combinationally on the cycle after the write edge. State encoding: 00 inactive, 01 pending, 10 active, 11 pending+active.
- R2: A software write with link flag 1 and state 11 is rejected. The entry keeps its previous contents, and `sw_wr_reject` is high for exactly the cycle after the write.
- R3: An acknowledge picks the lowest-index entry in state 01. Entries in state 11 are not eligible. On the cycle after the request, `g_ack_valid` is high and `g_ack_vid` holds that entry's virtual ID, and the entry is now in state 10.
- R4: An acknowledge when no entry is in state 01 returns virtual ID 1023 with `g_ack_valid` high and changes no entry.
- R5: A deactivate picks the lowest-index entry whose state has bit 1 set, whose forwarded flag is clear and whose virtual ID equals `g_deact_vid`. If that entry is unlinked, bit 1 of its state is cleared (10 becomes 00, 11 becomes 01).
- R6: If the matched entry is linked, its state is unchanged and its forwarded flag is set. On the next cycle, `pd_deact_valid` is high for one cycle and `pd_deact_pid` carries the entry's physical ID.
- R7: A deactivate that matches no entry changes no entry and emits no physical request. It sets `g_deact_err`, which stays high until reset.
- R8: After reset all entries are inactive and unlinked with zero IDs, and all outputs driven by the block are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software entry write strobe |
| sw_wr_idx | input | IDX_W | Entry written |
| sw_wr_vid | input | VID_W | Virtual ID to load |
| sw_wr_pid | input | PID_W | Physical ID to load |
| sw_wr_hw | input | 1 | Link flag to load |
| sw_wr_state | input | 2 | State to load |
| sw_wr_reject | output | 1 | Pulse: last write was illegal and dropped |
| sw_rd_idx | input | IDX_W | Entry read back |
| sw_rd_vid | output | VID_W | Read-back virtual ID |
| sw_rd_pid | output | PID_W | Read-back physical ID |
| sw_rd_hw | output | 1 | Read-back link flag |
| sw_rd_state | output | 2 | Read-back state |
| sw_rd_done | output | 1 | Read-back forwarded flag |
| g_ack_req | input | 1 | Guest acknowledge request |
| g_ack_valid | output | 1 | Acknowledge result valid |
| g_ack_vid | output | VID_W | Acknowledged virtual ID, or 1023 |
| g_deact_req | input | 1 | Guest deactivate request |
| g_deact_vid | input | VID_W | Virtual ID deactivated |
| g_deact_err | output | 1 | Sticky unmatched-deactivate flag |
| pd_deact_valid | output | 1 | Physical deactivate strobe |
| pd_deact_pid | output | PID_W | Physical ID to deactivate |

## Verification
The assertions check on every cycle that no linked entry ever holds state 11. They also check that every reject, acknowledge result and physical strobe follows the request that causes it, and that the error flag never falls. Only the bench scenarios can show the values involved. These are the order of lowest-index selection, the 1023 reply, the exact state transitions on deactivate, and that a linked entry stays active until software rewrites it.

// File: rtl/lrb_pkg.sv
// Shared types for the list register bank.
// Assumes nothing beyond the two-bit state encoding below.
package lrb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PEND = 2'b01,
        ST_ACT  = 2'b10,
        ST_PACT = 2'b11
    } lr_state_e;
endpackage

// File: rtl/lrb_entry.sv
// One list entry: holds IDs, link flag, state and forwarded flag.
// Assumes the parent only raises ack_hit on a pending entry and
// deact_hit on an active, not-yet-forwarded entry; a write wins over both.
module lrb_entry
    import lrb_pkg::*;
#(
    parameter int VID_W = 10,
    parameter int PID_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VID_W-1:0] wr_vid,
    input  logic [PID_W-1:0] wr_pid,
    input  logic             wr_hw,
    input  lr_state_e        wr_state,
    input  logic             ack_hit,
    input  logic             deact_hit,
    output logic [VID_W-1:0] vid,
    output logic [PID_W-1:0] pid,
    output logic             hw,
    output lr_state_e        state,
    output logic             done
);
    // Entry update: reset, software load, acknowledge, deactivate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid   <= '0;
            pid   <= '0;
            hw    <= 1'b0;
            state <= ST_IDLE;
            done  <= 1'b0;
        end else if (wr_en) begin
            vid   <= wr_vid;
            pid   <= wr_pid;
            hw    <= wr_hw;
            state <= wr_state;
            done  <= 1'b0;
        end else if (ack_hit) begin
            state <= ST_ACT;
        end else if (deact_hit) begin
            if (hw) begin
                done <= 1'b1;
            end else begin
                state <= lr_state_e'({1'b0, state[0]});
            end
        end
    end
endmodule

// File: rtl/lrb_lowest.sv
// Lowest-index-wins finder over a request vector.
// Assumes N >= 1; idx is zero when nothing is found.
module lrb_lowest #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/lrb_bank.sv
// List register bank top: N entries, software write/read port, guest
// acknowledge and deactivate, physical deactivate forwarding.
// Assumes one software write and at most one of each guest operation
// per cycle; results appear one cycle after the request.
module lrb_bank
    import lrb_pkg::*;
#(
    parameter int N     = 4,
    parameter int VID_W = 10,
    parameter int PID_W = 10,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_en,
    input  logic [IDX_W-1:0] sw_wr_idx,
    input  logic [VID_W-1:0] sw_wr_vid,
    input  logic [PID_W-1:0] sw_wr_pid,
    input  logic             sw_wr_hw,
    input  logic [1:0]       sw_wr_state,
    output logic             sw_wr_reject,
    input  logic [IDX_W-1:0] sw_rd_idx,
    output logic [VID_W-1:0] sw_rd_vid,
    output logic [PID_W-1:0] sw_rd_pid,
    output logic             sw_rd_hw,
    output logic [1:0]       sw_rd_state,
    output logic             sw_rd_done,
    input  logic             g_ack_req,
    output logic             g_ack_valid,
    output logic [VID_W-1:0] g_ack_vid,
    input  logic             g_deact_req,
    input  logic [VID_W-1:0] g_deact_vid,
    output logic             g_deact_err,
    output logic             pd_deact_valid,
    output logic [PID_W-1:0] pd_deact_pid
);
    localparam logic [VID_W-1:0] SPURIOUS = {VID_W{1'b1}};

    logic [VID_W-1:0] e_vid   [N];
    logic [PID_W-1:0] e_pid   [N];
    logic             e_hw    [N];
    lr_state_e        e_state [N];
    logic             e_done  [N];

    logic [N-1:0]     pend_vec;
    logic [N-1:0]     match_vec;
    logic             ack_found, deact_found;
    logic [IDX_W-1:0] ack_idx, deact_idx;
    logic             wr_illegal, wr_ok;

    // Linked entries may not be loaded as pending+active.
    assign wr_illegal = sw_wr_en && sw_wr_hw && (sw_wr_state == 2'b11);
    assign wr_ok      = sw_wr_en && !wr_illegal;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_ent
            // Eligibility of each entry for the two guest operations.
            assign pend_vec[gi]  = (e_state[gi] == ST_PEND);
            assign match_vec[gi] = e_state[gi][1] && !e_done[gi] &&
                                   (e_vid[gi] == g_deact_vid);

            lrb_entry #(.VID_W(VID_W), .PID_W(PID_W)) u_entry (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (wr_ok && (sw_wr_idx == IDX_W'(gi))),
                .wr_vid    (sw_wr_vid),
                .wr_pid    (sw_wr_pid),
                .wr_hw     (sw_wr_hw),
                .wr_state  (lr_state_e'(sw_wr_state)),
                .ack_hit   (g_ack_req && ack_found && (ack_idx == IDX_W'(gi))),
                .deact_hit (g_deact_req && deact_found && (deact_idx == IDX_W'(gi))),
                .vid       (e_vid[gi]),
                .pid       (e_pid[gi]),
                .hw        (e_hw[gi]),
                .state     (e_state[gi]),
                .done      (e_done[gi])
            );

            assert_linked_no_pact_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !(e_hw[gi] && e_state[gi] == ST_PACT));
        end
    endgenerate

    lrb_lowest #(.N(N), .IDX_W(IDX_W)) u_ack_scan (
        .req(pend_vec), .found(ack_found), .idx(ack_idx)
    );

    lrb_lowest #(.N(N), .IDX_W(IDX_W)) u_deact_scan (
        .req(match_vec), .found(deact_found), .idx(deact_idx)
    );

    // Software read-back of the selected entry.
    always_comb begin
        sw_rd_vid   = e_vid[sw_rd_idx];
        sw_rd_pid   = e_pid[sw_rd_idx];
        sw_rd_hw    = e_hw[sw_rd_idx];
        sw_rd_state = e_state[sw_rd_idx];
        sw_rd_done  = e_done[sw_rd_idx];
    end

    // Registered results of writes and guest operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_wr_reject   <= 1'b0;
            g_ack_valid    <= 1'b0;
            g_ack_vid      <= '0;
            g_deact_err    <= 1'b0;
            pd_deact_valid <= 1'b0;
            pd_deact_pid   <= '0;
        end else begin
            sw_wr_reject   <= wr_illegal;
            g_ack_valid    <= g_ack_req;
            if (g_ack_req) g_ack_vid <= ack_found ? e_vid[ack_idx] : SPURIOUS;
            pd_deact_valid <= g_deact_req && deact_found && e_hw[deact_idx];
            if (g_deact_req && deact_found) pd_deact_pid <= e_pid[deact_idx];
            if (g_deact_req && !deact_found) g_deact_err <= 1'b1;
        end
    end

    assert_reject_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_reject |-> $past(sw_wr_en && sw_wr_hw && sw_wr_state == 2'b11));
    assert_ack_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        g_ack_req |=> g_ack_valid);
    assert_ack_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        g_ack_valid |-> $past(g_ack_req));
    assert_pd_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pd_deact_valid |-> $past(g_deact_req));
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        g_deact_err |=> g_deact_err);
endmodule

// File: tb/lrb_bank_bench.sv
module lrb_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4, VID_W = 10, PID_W = 10, IDX_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_wr_en = 1'b0, sw_wr_hw = 1'b0;
    logic [IDX_W-1:0] sw_wr_idx = '0, sw_rd_idx = '0;
    logic [VID_W-1:0] sw_wr_vid = '0, g_deact_vid = '0;
    logic [PID_W-1:0] sw_wr_pid = '0;
    logic [1:0] sw_wr_state = '0;
    logic g_ack_req = 1'b0, g_deact_req = 1'b0;
    logic sw_wr_reject, sw_rd_hw, sw_rd_done, g_ack_valid, g_deact_err, pd_deact_valid;
    logic [VID_W-1:0] sw_rd_vid, g_ack_vid;
    logic [PID_W-1:0] sw_rd_pid, pd_deact_pid;
    logic [1:0] sw_rd_state;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [VID_W-1:0] ack_q[$];
    logic [PID_W-1:0] pd_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lrb_bank #(.N(N), .VID_W(VID_W), .PID_W(PID_W)) u_lrb_bank (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sw_write(input int idx, input int vid, input int pid, input bit hw, input int st);
        sw_wr_en = 1'b1; sw_wr_idx = IDX_W'(idx); sw_wr_vid = VID_W'(vid);
        sw_wr_pid = PID_W'(pid); sw_wr_hw = hw; sw_wr_state = 2'(st);
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic guest_ack(input int exp_vid);
        ack_q.push_back(VID_W'(exp_vid));
        g_ack_req = 1'b1;
        @(negedge clk);
        g_ack_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic guest_deact(input int vid, input bit expect_pd, input int exp_pid);
        if (expect_pd) pd_q.push_back(PID_W'(exp_pid));
        g_deact_req = 1'b1; g_deact_vid = VID_W'(vid);
        @(negedge clk);
        g_deact_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input int idx);
        sw_rd_idx = IDX_W'(idx);
        #1;
    endtask

    // Monitor: pop expected results as the design produces them.
    always @(negedge clk) begin
        if (rst_n && g_ack_valid) begin
            if (ack_q.size() == 0) check("R3 unexpected ack", 1, 0);
            else check("R3/R4 ack vid", 32'(g_ack_vid), 32'(ack_q.pop_front()));
        end
        if (rst_n && pd_deact_valid) begin
            if (pd_q.size() == 0) check("R7 unexpected pd strobe", 1, 0);
            else check("R6 pd pid", 32'(pd_deact_pid), 32'(pd_q.pop_front()));
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rd(0);
        check("R8 reset state", 32'(sw_rd_state), 0);
        check("R8 reset ack_valid", 32'(g_ack_valid), 0);
        check("R8 reset err", 32'(g_deact_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        sw_write(0, 5, 40, 0, 1);
        sw_write(1, 7, 77, 1, 1);
        sw_write(2, 9, 90, 0, 0);
        sw_write(3, 11, 33, 0, 3);
        rd(1);
        check("R1 vid", 32'(sw_rd_vid), 7);
        check("R1 pid", 32'(sw_rd_pid), 77);
        check("R1 hw", 32'(sw_rd_hw), 1);
        check("R1 state", 32'(sw_rd_state), 1);

        sw_write(2, 100, 1, 1, 3);
        check("R2 reject pulse", 32'(sw_wr_reject), 1);
        rd(2);
        check("R2 entry kept hw", 32'(sw_rd_hw), 0);
        check("R2 entry kept vid", 32'(sw_rd_vid), 9);
        @(negedge clk);
        check("R2 reject one cycle", 32'(sw_wr_reject), 0);

        guest_ack(5);
        rd(0); check("R3 acked entry active", 32'(sw_rd_state), 2);
        guest_ack(7);
        rd(1); check("R3 second entry active", 32'(sw_rd_state), 2);
        guest_ack(1023);
        rd(3); check("R4 pact entry untouched", 32'(sw_rd_state), 3);

        guest_deact(5, 0, 0);
        rd(0); check("R5 unlinked 10->00", 32'(sw_rd_state), 0);
        guest_deact(11, 0, 0);
        rd(3); check("R5 unlinked 11->01", 32'(sw_rd_state), 1);
        guest_ack(11);

        guest_deact(7, 1, 77);
        rd(1);
        check("R6 linked stays active", 32'(sw_rd_state), 2);
        check("R6 forwarded flag", 32'(sw_rd_done), 1);
        check("R6 no error", 32'(g_deact_err), 0);

        guest_deact(7, 0, 0);
        check("R7 err set", 32'(g_deact_err), 1);
        rd(1); check("R7 entry unchanged", 32'(sw_rd_state), 2);
        guest_deact(11, 0, 0);
        check("R7 err sticky", 32'(g_deact_err), 1);

        sw_write(1, 7, 77, 1, 0);
        rd(1);
        check("R1 write clears state", 32'(sw_rd_state), 0);
        check("R1 write clears forwarded", 32'(sw_rd_done), 0);

        repeat (2) @(negedge clk);
        check("R3 ack queue drained", 32'(ack_q.size()), 0);
        check("R6 pd queue drained", 32'(pd_q.size()), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule